// File: doc/BRIEF.md
# E1 Transmit Framer with Signalling Multiframe

This block builds the outgoing 2.048 Mbit/s primary-rate stream. Each frame has 32 eight-bit time slots. Slot 0 carries the framing overhead. Slot 16 carries either the multiframe alignment byte or a signalling byte. The other 30 slots carry voice samples. Frames are counted modulo 16 to form a signalling multiframe. The block emits one line bit each time its bit-rate enable is high, most significant bit of each slot first.

Slot 0 content alternates between frames. Even frames send a check bit followed by the fixed alignment word. Odd frames send the check bit, a forced one, the remote alarm bit and five spare national bits. In frame 0 of the multiframe, slot 16 holds a zero nibble, three spare bits and the multiframe alarm bit. In frames 1 to 15, slot 16 holds signalling supplied by the source, the same way as a voice byte. The check-bit value comes from an input, because the CRC calculation lives elsewhere.

Voice and signalling bytes are fetched through a request output. The request names the slot one full slot period before that slot goes out, so the source has a whole slot time to answer. Alarm, spare-bit and check-bit inputs are captured once per frame, so one frame never carries a mix of old and new values.

Top module: `e1_frame_gen`

## Requirements
- R1: After reset and before the first bit enable, tx_bit is 1 and frame_sync, mf_sync and req_valid are all low.
- R2: Each clock with bit_en high advances the stream by exactly one bit. When bit_en is low, tx_bit and every strobe hold their values.
- R3: Every frame is 256 bits long: 32 slots of 8 bits, each sent MSB first. frame_sync is high for exactly the first bit of slot 0.
- R4: Frames are numbered 0 to 15 and wrap. mf_sync is high only on the first bit of slot 0 of frame 0.
- R5: In even frames, slot 0 is the captured check bit followed by 0011011.
- R6: In odd frames, slot 0 is the captured check bit, then 1, then remote_alarm, then nat_bits[4] down to nat_bits[0].
- R7: In frame 0, slot 16 is 0000, then mf_spare[2], mf_alarm, mf_spare[1], mf_spare[0]. This byte is never requested from the source.
- R8: During the first bit of slot k-1, req_valid is high with req_slot = k and req_frame = current frame number. This applies to every k from 1 to 31 except slot 16 of frame 0. chan_data is sampled at the end of slot k-1 and sent unchanged in slot k.
- R9: crc_bit, remote_alarm, nat_bits, mf_alarm and mf_spare are captured only on the bit enable that starts slot 0. Changes made later in the frame do not reach the current frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | Bit-rate enable; one line bit per high cycle |
| chan_data | input | 8 | Byte for the requested slot |
| crc_bit | input | 1 | Check bit placed first in slot 0 |
| remote_alarm | input | 1 | Far-end alarm bit for odd-frame slot 0 |
| nat_bits | input | 5 | Spare national bits for odd-frame slot 0 |
| mf_alarm | input | 1 | Multiframe alarm bit for frame-0 slot 16 |
| mf_spare | input | 3 | Spare bits for frame-0 slot 16 |
| tx_bit | output | 1 | Serial line bit |
| frame_sync | output | 1 | High on the first bit of slot 0 |
| mf_sync | output | 1 | High on the first bit of frame 0 |
| req_valid | output | 1 | Byte request for the next slot |
| req_slot | output | 5 | Slot number being requested |
| req_frame | output | 4 | Frame number of the requested slot |

## Verification
Several properties are checked on every cycle:
- tx_bit is frozen while bit_en is low.
- frame_sync lasts only one bit.
- The second bit of slot 0 takes the fixed value for the frame parity.
- The alignment nibble of frame-0 slot 16 is zero.
- No request is ever raised for slot 0 or for the frame-0 signalling slot.

Other behaviour can only be shown by the bench's bit-exact model across three multiframes, with gaps in bit_en:
- the full content of every slot;
- that a fetched byte lands in the right slot;
- that config changes made in the middle of a frame stay out of that frame.

// File: rtl/e1_tx_pkg.sv
package e1_tx_pkg;

  localparam int BYTE_W = 8;
  localparam int NAT_W  = 5;
  localparam int SPR_W  = 3;

  // Alignment word sent after the check bit in even frames.
  localparam logic [6:0] ALIGN_WORD = 7'b0011011;

  // Slot-0 byte: even frames carry the alignment word; odd frames carry
  // a forced 1, the remote alarm and the national bits.
  function automatic logic [BYTE_W-1:0] slot0_byte(input logic odd,
                                                  input logic chk,
                                                  input logic ralarm,
                                                  input logic [NAT_W-1:0] nat);
    logic [BYTE_W-1:0] b;
    if (odd) b = {chk, 1'b1, ralarm, nat};
    else     b = {chk, ALIGN_WORD};
    return b;
  endfunction

  // Multiframe alignment byte for slot 16 of frame 0.
  function automatic logic [BYTE_W-1:0] mfa_byte(input logic alarm,
                                                 input logic [SPR_W-1:0] spare);
    return {4'b0000, spare[2], alarm, spare[1:0]};
  endfunction

  // A slot is fetched from the source unless the block builds it itself.
  function automatic logic slot_is_fetched(input int unsigned slot,
                                           input int unsigned frame,
                                           input int unsigned sig_slot);
    return (slot != 0) && !((slot == sig_slot) && (frame == 0));
  endfunction

endpackage

// File: rtl/e1_tx_position.sv
module e1_tx_position #(
  parameter int SLOTS  = 32,
  parameter int BITS   = 8,
  parameter int FRAMES = 16,
  localparam int SW = $clog2(SLOTS),
  localparam int BW = $clog2(BITS),
  localparam int FW = $clog2(FRAMES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  output logic [BW-1:0] pos_bit,
  output logic [SW-1:0] pos_slot,
  output logic [FW-1:0] pos_frame,
  output logic          slot_step,
  output logic [SW-1:0] nxt_slot,
  output logic [FW-1:0] nxt_frame
);

  logic last_bit, last_slot, last_frame;

  assign last_bit   = (pos_bit   == BW'(BITS - 1));
  assign last_slot  = (pos_slot  == SW'(SLOTS - 1));
  assign last_frame = (pos_frame == FW'(FRAMES - 1));
  assign slot_step  = bit_en && last_bit;

  always_comb begin
    nxt_slot  = last_slot ? '0 : pos_slot + SW'(1);
    nxt_frame = pos_frame;
    if (last_slot) nxt_frame = last_frame ? '0 : pos_frame + FW'(1);
  end

  // Reset parks the counters on the last bit of the last frame, so the
  // first enable lands on bit 0 of slot 0 of frame 0.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_bit   <= BW'(BITS - 1);
      pos_slot  <= SW'(SLOTS - 1);
      pos_frame <= FW'(FRAMES - 1);
    end else if (bit_en) begin
      if (last_bit) begin
        pos_bit   <= '0;
        pos_slot  <= nxt_slot;
        pos_frame <= nxt_frame;
      end else begin
        pos_bit <= pos_bit + BW'(1);
      end
    end
  end

endmodule

// File: rtl/e1_tx_cfg_latch.sv
module e1_tx_cfg_latch
  import e1_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_load,
  input  logic             mf_alarm,
  input  logic [SPR_W-1:0] mf_spare,
  output logic             mf_alarm_q,
  output logic [SPR_W-1:0] mf_spare_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mf_alarm_q <= 1'b0;
      mf_spare_q <= '0;
    end else if (frame_load) begin
      mf_alarm_q <= mf_alarm;
      mf_spare_q <= mf_spare;
    end
  end

endmodule

// File: rtl/e1_tx_byte_select.sv
module e1_tx_byte_select
  import e1_tx_pkg::*;
#(
  parameter int SW       = 5,
  parameter int FW       = 4,
  parameter int SIG_SLOT = 16
) (
  input  logic [SW-1:0]     nxt_slot,
  input  logic [FW-1:0]     nxt_frame,
  input  logic [FW-1:0]     cur_frame,
  input  logic [BYTE_W-1:0] chan_data,
  input  logic              crc_bit,
  input  logic              remote_alarm,
  input  logic [NAT_W-1:0]  nat_bits,
  input  logic              mf_alarm_q,
  input  logic [SPR_W-1:0]  mf_spare_q,
  output logic [BYTE_W-1:0] load_byte
);

  always_comb begin
    if (nxt_slot == '0)
      load_byte = slot0_byte(nxt_frame[0], crc_bit, remote_alarm, nat_bits);
    else if (nxt_slot == SW'(SIG_SLOT) && cur_frame == '0)
      load_byte = mfa_byte(mf_alarm_q, mf_spare_q);
    else
      load_byte = chan_data;
  end

endmodule

// File: rtl/e1_tx_shifter.sv
module e1_tx_shifter #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_en,
  input  logic            load,
  input  logic [BITS-1:0] load_byte,
  output logic            ser_out
);

  logic [BITS-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sr <= '1;
    else if (load)   sr <= load_byte;
    else if (bit_en) sr <= {sr[BITS-2:0], 1'b1};
  end

  assign ser_out = sr[BITS-1];

endmodule

// File: rtl/e1_frame_gen.sv
module e1_frame_gen
  import e1_tx_pkg::*;
#(
  parameter int SLOTS  = 32,
  parameter int FRAMES = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bit_en,
  input  logic [7:0]                 chan_data,
  input  logic                       crc_bit,
  input  logic                       remote_alarm,
  input  logic [4:0]                 nat_bits,
  input  logic                       mf_alarm,
  input  logic [2:0]                 mf_spare,
  output logic                       tx_bit,
  output logic                       frame_sync,
  output logic                       mf_sync,
  output logic                       req_valid,
  output logic [$clog2(SLOTS)-1:0]   req_slot,
  output logic [$clog2(FRAMES)-1:0]  req_frame
);

  localparam int SW       = $clog2(SLOTS);
  localparam int BW       = $clog2(BYTE_W);
  localparam int FW       = $clog2(FRAMES);
  localparam int SIG_SLOT = SLOTS / 2;

  // Position and timing events, named so the checker can use them.
  logic [BW-1:0]     pos_bit;
  logic [SW-1:0]     pos_slot;
  logic [FW-1:0]     pos_frame;
  logic              slot_step;
  logic [SW-1:0]     nxt_slot;
  logic [FW-1:0]     nxt_frame;
  logic              frame_load;
  logic              mf_alarm_q;
  logic [SPR_W-1:0]  mf_spare_q;
  logic [BYTE_W-1:0] load_byte;
  logic [SW-1:0]     ahead_slot;

  e1_tx_position #(.SLOTS(SLOTS), .BITS(BYTE_W), .FRAMES(FRAMES)) u_pos (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
    .pos_bit(pos_bit), .pos_slot(pos_slot), .pos_frame(pos_frame),
    .slot_step(slot_step), .nxt_slot(nxt_slot), .nxt_frame(nxt_frame)
  );

  assign frame_load = slot_step && (nxt_slot == '0);

  e1_tx_cfg_latch u_cfg (
    .clk(clk), .rst_n(rst_n), .frame_load(frame_load),
    .mf_alarm(mf_alarm), .mf_spare(mf_spare),
    .mf_alarm_q(mf_alarm_q), .mf_spare_q(mf_spare_q)
  );

  e1_tx_byte_select #(.SW(SW), .FW(FW), .SIG_SLOT(SIG_SLOT)) u_sel (
    .nxt_slot(nxt_slot), .nxt_frame(nxt_frame), .cur_frame(pos_frame),
    .chan_data(chan_data), .crc_bit(crc_bit), .remote_alarm(remote_alarm),
    .nat_bits(nat_bits), .mf_alarm_q(mf_alarm_q), .mf_spare_q(mf_spare_q),
    .load_byte(load_byte)
  );

  e1_tx_shifter #(.BITS(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .load(slot_step),
    .load_byte(load_byte), .ser_out(tx_bit)
  );

  // Request the byte for the following slot during the first bit of the
  // current one; the last slot never requests (slot 0 is built locally).
  assign ahead_slot = pos_slot + SW'(1);
  assign req_slot   = ahead_slot;
  assign req_frame  = pos_frame;
  assign req_valid  = (pos_bit == '0) && (pos_slot != SW'(SLOTS - 1)) &&
                      slot_is_fetched(int'(ahead_slot), int'(pos_frame), SIG_SLOT);

  assign frame_sync = (pos_slot == '0) && (pos_bit == '0);
  assign mf_sync    = frame_sync && (pos_frame == '0);

endmodule

// File: rtl/e1_frame_gen_sva.sv
module e1_frame_gen_sva #(
  parameter int SW = 5,
  parameter int BW = 3,
  parameter int FW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_en,
  input logic          tx_bit,
  input logic          frame_sync,
  input logic          mf_sync,
  input logic          req_valid,
  input logic [SW-1:0] req_slot,
  input logic [FW-1:0] req_frame,
  input logic [BW-1:0] pos_bit,
  input logic [SW-1:0] pos_slot,
  input logic [FW-1:0] pos_frame
);

  localparam logic [SW-1:0] SIG = SW'(16);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(tx_bit) && $stable(frame_sync));

  p_sync_one_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_sync && bit_en) |=> !frame_sync);

  p_mf_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mf_sync |-> (req_valid && req_slot == SW'(1) && req_frame == '0));

  p_even_bit1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_slot == '0 && pos_bit == BW'(1) && !pos_frame[0]) |-> !tx_bit);

  p_odd_bit1_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_slot == '0 && pos_bit == BW'(1) && pos_frame[0]) |-> tx_bit);

  p_mfa_nibble_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_frame == '0 && pos_slot == SIG && pos_bit < BW'(4)) |-> !tx_bit);

  p_req_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_slot != '0 && !(req_slot == SIG && req_frame == '0)));

endmodule

bind e1_frame_gen e1_frame_gen_sva #(.SW(SW), .BW(BW), .FW(FW)) u_sva (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_bit(tx_bit),
  .frame_sync(frame_sync), .mf_sync(mf_sync), .req_valid(req_valid),
  .req_slot(req_slot), .req_frame(req_frame),
  .pos_bit(pos_bit), .pos_slot(pos_slot), .pos_frame(pos_frame)
);

// File: tb/e1_frame_gen_tb.sv
module e1_frame_gen_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic [7:0] chan_data = 8'h00;
  logic       crc_bit = 1'b0;
  logic       remote_alarm = 1'b0;
  logic [4:0] nat_bits = 5'd0;
  logic       mf_alarm = 1'b0;
  logic [2:0] mf_spare = 3'd0;
  logic       tx_bit, frame_sync, mf_sync, req_valid;
  logic [4:0] req_slot;
  logic [3:0] req_frame;

  e1_frame_gen u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .chan_data(chan_data),
    .crc_bit(crc_bit), .remote_alarm(remote_alarm), .nat_bits(nat_bits),
    .mf_alarm(mf_alarm), .mf_spare(mf_spare), .tx_bit(tx_bit),
    .frame_sync(frame_sync), .mf_sync(mf_sync), .req_valid(req_valid),
    .req_slot(req_slot), .req_frame(req_frame)
  );

  always #10 clk = ~clk;

  localparam int TARGET = 3 * 4096 + 300;

  int checks = 0;
  int failures = 0;
  int nbits = 0;
  int cyc = 0;
  bit prev_en = 1'b0;
  // Config captured by the model at each frame start.
  int s_crc = 0, s_ra = 0, s_nat = 0, s_mfa = 0, s_spr = 0;

  task automatic chk(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d bit=%0d", tag, what, act, exp, nbits);
    end
  endtask

  function automatic int vbyte(input int fa, input int s);
    return (fa * 29 + s * 13 + 7) % 256;
  endfunction

  function automatic int model_byte(input int fa, input int s);
    int m = fa % 16;
    if (s == 0) begin
      if (fa % 2 == 0) return s_crc * 128 + 27;
      return s_crc * 128 + 64 + s_ra * 32 + s_nat;
    end
    if (s == 16 && m == 0)
      return (s_spr / 4) * 8 + s_mfa * 4 + (s_spr % 4);
    return vbyte(fa, s);
  endfunction

  function automatic bit cfg_moved();
    return (int'(crc_bit) != s_crc) || (int'(remote_alarm) != s_ra) ||
           (int'(nat_bits) != s_nat) || (int'(mf_alarm) != s_mfa) ||
           (int'(mf_spare) != s_spr);
  endfunction

  task automatic compare();
    int g, fa, s, b, m, etx;
    bit ereq, efs;
    string tag;
    if (nbits == 0) begin
      chk("R1", int'(tx_bit), 1, "idle tx_bit");
      chk("R1", int'(frame_sync), 0, "idle frame_sync");
      chk("R1", int'(mf_sync), 0, "idle mf_sync");
      chk("R1", int'(req_valid), 0, "idle req_valid");
      return;
    end
    g = nbits - 1; fa = g / 256; s = (g / 8) % 32; b = g % 8; m = fa % 16;
    etx = (model_byte(fa, s) >> (7 - b)) & 1;
    if (!prev_en) tag = "R2";
    else if (s == 0) tag = (fa % 2 == 0) ? "R5" : "R6";
    else if (s == 16 && m == 0) tag = "R7";
    else tag = "R8";
    // R9: a mid-frame config change must not show in this frame's overhead
    if ((s == 0 || (s == 16 && m == 0)) && cfg_moved()) tag = "R9";
    chk(tag, int'(tx_bit), etx, "tx_bit");
    efs = (s == 0 && b == 0);
    chk("R3", int'(frame_sync), int'(efs), "frame_sync");
    chk("R4", int'(mf_sync), int'(efs && m == 0), "mf_sync");
    ereq = (b == 0) && (s < 31) && !((s + 1) == 16 && m == 0);
    chk((s == 15 && m == 0) ? "R7" : "R8", int'(req_valid), int'(ereq), "req_valid");
    if (ereq) begin
      chk("R8", int'(req_slot), s + 1, "req_slot");
      chk("R8", int'(req_frame), m, "req_frame");
      chan_data = 8'(vbyte(fa, s + 1));
    end
  endtask

  task automatic drive();
    cyc++;
    crc_bit      = 1'((nbits / 97) % 2);
    remote_alarm = 1'((nbits / 300) % 2);
    nat_bits     = 5'((nbits / 170) % 32);
    mf_alarm     = 1'((nbits / 1000) % 2);
    mf_spare     = 3'((nbits / 411) % 8);
    bit_en = !((cyc % 9) == 4) && !(cyc >= 3000 && cyc < 3025);
    if (bit_en && (nbits % 256 == 0)) begin
      s_crc = int'(crc_bit); s_ra = int'(remote_alarm); s_nat = int'(nat_bits);
      s_mfa = int'(mf_alarm); s_spr = int'(mf_spare);
    end
    prev_en = bit_en;
    if (bit_en) nbits++;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      compare();
    end
    forever begin
      @(negedge clk);
      compare();
      if (nbits >= TARGET) finish_run();
      drive();
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R2 watchdog actual=%0d expected=%0d", nbits, TARGET);
    finish_run();
  end

endmodule